// File: doc/BRIEF.md
# Priority-Ordered Peripheral Pin Crossbar

This block connects the signals of a fixed set of on-chip digital peripherals to a bank of general-purpose pins. The pins are grouped into byte-wide ports. Software enables peripheral groups, marks pins to be passed over, and sets each pin's mode. The crossbar then hands out pins from pin 0 upward. Each enabled group, in a fixed priority order, takes a contiguous run of the next pins that are still free. A pin that receives no peripheral signal stays general-purpose I/O and is driven from its port latch.

Every pin has its own settings: analog or digital, skip, and push-pull or open-drain output. One global bit switches all weak pull-ups off, and one master bit enables the whole crossbar. Allocation is purely combinational from the configuration inputs, so a pin assignment follows a register change within the same cycle. The pad cells and the peripherals themselves sit outside this block.

Top module: `pin_crossbar`

## Requirements
- R1: While `xbar_en` is 0, no pin is driven (`pad_oe` all 0) and every bit of `periph_in` reads 1.
- R2: Groups are granted in priority order, highest first, by `grp_en` bit. Bit 0 is serial A (2 signals), bit 1 is the synchronous serial port (4), bit 2 is the two-wire bus (2), bit 3 is comparator A (2), bit 4 is comparator B (2), bit 5 is the clock output (1), bit 6 is the capture/PWM array (6), bit 7 is the timers (2) and bit 8 is serial B (2). Signals are numbered 0 to 22 in that order.
- R3: Enabled signals take the free pins from pin 0 upward, in ascending signal index. A disabled group takes no pin. Pin p is bit p of every pin vector, and port k holds pins 8k to 8k+7.
- R4: A pin with its `pin_skip` bit set is never given a peripheral signal and stays general-purpose I/O.
- R5: A pin with `pin_digital` 0 (analog) gets no signal and is never driven. It has no pull-up, and its `gpio_in` bit reads 0.
- R6: A digital pin with no peripheral signal drives its `port_latch` bit.
- R7: In open-drain mode (`pin_pushpull` 0), a value of 1 leaves the pin undriven, and a value of 0 drives it low.
- R8: An assigned pin whose peripheral holds its `periph_oe` bit at 0 is not driven.
- R9: A pin's pull-up is on only if `pullup_off` is 0, the pin is digital, and the pin is not actively driving low.
- R10: When the free pins run out, the remaining lowest-priority signals stay unconnected, and their `periph_in` bits read 1.
- R11: Each `periph_in` bit of an assigned signal equals the `pad_in` bit of its pin.
- R12: A change to any configuration input changes the pin outputs without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks only |
| rst_n | input | 1 | Active-low reset for the embedded checks |
| xbar_en | input | 1 | Master crossbar enable |
| grp_en | input | 9 | Per-group enable, bit 0 highest priority |
| pin_skip | input | 32 | Pin passed over by allocation |
| pin_digital | input | 32 | 1 digital, 0 analog |
| pin_pushpull | input | 32 | 1 push-pull, 0 open-drain |
| pullup_off | input | 1 | Global weak pull-up disable |
| periph_out | input | 23 | Peripheral output values |
| periph_oe | input | 23 | Peripheral output enables |
| port_latch | input | 32 | General-purpose output latches |
| pad_in | input | 32 | Pin input levels |
| pad_oe | output | 32 | Pin drive enable |
| pad_out | output | 32 | Pin drive value |
| pad_pullup | output | 32 | Weak pull-up enable |
| gpio_in | output | 32 | Digital pin read-back |
| periph_in | output | 23 | Routed pin inputs to peripherals |

## Verification
Two things can happen in the same cycle: a change to the skip map moves the allocation, and a peripheral changes its output or enable. The bench provokes this by changing `pin_skip` and `periph_out` together in the middle of a cycle. It then samples the pins one time unit later, before the next edge. The check passes only if the new value appears on the newly assigned pin and the pin that was given up falls back to its latch value.

// File: rtl/pxb_pkg.sv
package pxb_pkg;

   localparam int NUM_GRP = 9;
   localparam int GRP_W [NUM_GRP] = '{2, 4, 2, 2, 2, 1, 6, 2, 2};

   // first signal index of group g
   function automatic int grp_base(input int g);
      int acc;
      acc = 0;
      for (int i = 0; i < g; i++) acc += GRP_W[i];
      return acc;
   endfunction

   localparam int NUM_SIG = grp_base(NUM_GRP);

   // group that owns signal s
   function automatic int grp_of(input int s);
      int r;
      r = 0;
      for (int i = 0; i < NUM_GRP; i++)
         if (s >= grp_base(i)) r = i;
      return r;
   endfunction

endpackage

// File: rtl/pxb_alloc.sv
module pxb_alloc #(
   parameter int NPIN = 32,
   parameter int NSIG = 23,
   parameter int NGRP = 9,
   localparam int SIX = (NSIG > 1) ? $clog2(NSIG) : 1,
   localparam int PIX = (NPIN > 1) ? $clog2(NPIN) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NGRP-1:0]           grp_en,
   input  logic [NPIN-1:0]           free,
   output logic [NPIN-1:0]           pin_hit,
   output logic [NPIN-1:0][SIX-1:0]  pin_sel,
   output logic [NSIG-1:0]           sig_hit,
   output logic [NSIG-1:0][PIX-1:0]  sig_pin
);
   localparam int RW = $clog2(NPIN + NSIG + 1);

   logic [NSIG-1:0]         sig_en;
   logic [NPIN-1:0][RW-1:0] pin_rank;
   logic [NSIG-1:0][RW-1:0] sig_rank;

   for (genvar s = 0; s < NSIG; s++) begin : g_sig_en
      localparam int G = pxb_pkg::grp_of(s);
      assign sig_en[s] = grp_en[G];
   end

   // position of each pin among the free pins
   always_comb begin
      logic [RW-1:0] acc;
      acc = '0;
      for (int p = 0; p < NPIN; p++) begin
         pin_rank[p] = acc;
         acc = acc + RW'(free[p]);
      end
   end

   // position of each signal among the enabled signals
   always_comb begin
      logic [RW-1:0] acc;
      acc = '0;
      for (int s = 0; s < NSIG; s++) begin
         sig_rank[s] = acc;
         acc = acc + RW'(sig_en[s]);
      end
   end

   // pin side: which signal lands here
   always_comb begin
      for (int p = 0; p < NPIN; p++) begin
         pin_hit[p] = 1'b0;
         pin_sel[p] = '0;
         for (int s = 0; s < NSIG; s++) begin
            if (free[p] && sig_en[s] && (sig_rank[s] == pin_rank[p])) begin
               pin_hit[p] = 1'b1;
               pin_sel[p] = SIX'(s);
            end
         end
      end
   end

   // signal side: which pin serves it
   always_comb begin
      for (int s = 0; s < NSIG; s++) begin
         sig_hit[s] = 1'b0;
         sig_pin[s] = '0;
         for (int p = 0; p < NPIN; p++) begin
            if (free[p] && sig_en[s] && (sig_rank[s] == pin_rank[p])) begin
               sig_hit[s] = 1'b1;
               sig_pin[s] = PIX'(p);
            end
         end
      end
   end

   assert_pair_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pin_hit) == $countones(sig_hit));

   assert_top_group_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_en[0] && (|free)) |-> sig_hit[0]);

   for (genvar s = 0; s < NSIG; s++) begin : g_chk
      assert_pin_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
         sig_hit[s] |-> free[sig_pin[s]]);
   end

endmodule

// File: rtl/pxb_pad.sv
module pxb_pad (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic digital,
   input  logic pushpull,
   input  logic hit,
   input  logic sval,
   input  logic soe,
   input  logic latch,
   input  logic pu_off,
   output logic oe,
   output logic dout,
   output logic pu
);
   logic want;
   logic val;

   assign val  = hit ? sval : latch;
   assign want = active && (hit ? soe : 1'b1);

   always_comb begin
      if (pushpull) begin
         oe   = want;
         dout = want && val;
      end else begin
         oe   = want && !val;
         dout = 1'b0;
      end
   end

   assign pu = !pu_off && digital && !(oe && !dout);

   assert_od_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !pushpull && !hit && latch) |-> !oe);

   assert_gpio_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && pushpull && !hit) |-> (oe && (dout == latch)));

endmodule

// File: rtl/pxb_in_route.sv
module pxb_in_route #(
   parameter int NPIN = 32,
   parameter int NSIG = 23,
   localparam int PIX = (NPIN > 1) ? $clog2(NPIN) : 1
) (
   input  logic [NSIG-1:0]          sig_hit,
   input  logic [NSIG-1:0][PIX-1:0] sig_pin,
   input  logic [NPIN-1:0]          pad_in,
   output logic [NSIG-1:0]          periph_in
);
   for (genvar s = 0; s < NSIG; s++) begin : g_route
      assign periph_in[s] = sig_hit[s] ? pad_in[sig_pin[s]] : 1'b1;
   end
endmodule

// File: rtl/pin_crossbar.sv
module pin_crossbar
   import pxb_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int PORT_W    = 8,
   localparam int NPIN = NUM_PORTS * PORT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               xbar_en,
   input  logic [NUM_GRP-1:0] grp_en,
   input  logic [NPIN-1:0]    pin_skip,
   input  logic [NPIN-1:0]    pin_digital,
   input  logic [NPIN-1:0]    pin_pushpull,
   input  logic               pullup_off,
   input  logic [NUM_SIG-1:0] periph_out,
   input  logic [NUM_SIG-1:0] periph_oe,
   input  logic [NPIN-1:0]    port_latch,
   input  logic [NPIN-1:0]    pad_in,
   output logic [NPIN-1:0]    pad_oe,
   output logic [NPIN-1:0]    pad_out,
   output logic [NPIN-1:0]    pad_pullup,
   output logic [NPIN-1:0]    gpio_in,
   output logic [NUM_SIG-1:0] periph_in
);
   localparam int SIX = (NUM_SIG > 1) ? $clog2(NUM_SIG) : 1;
   localparam int PIX = (NPIN > 1) ? $clog2(NPIN) : 1;

   if (NUM_PORTS < 1 || PORT_W < 1) begin : g_bad_geom
      $error("pin_crossbar: port geometry must be non-empty");
   end
   if (NPIN > 1024) begin : g_bad_size
      $error("pin_crossbar: pin count too large for the rank compare");
   end

   logic [NPIN-1:0]             free;
   logic [NUM_GRP-1:0]          grp_live;
   logic [NPIN-1:0]             pin_hit;
   logic [NPIN-1:0][SIX-1:0]    pin_sel;
   logic [NUM_SIG-1:0]          sig_hit;
   logic [NUM_SIG-1:0][PIX-1:0] sig_pin;

   assign free     = pin_digital & ~pin_skip;
   assign grp_live = grp_en & {NUM_GRP{xbar_en}};
   assign gpio_in  = pad_in & pin_digital;

   pxb_alloc #(.NPIN(NPIN), .NSIG(NUM_SIG), .NGRP(NUM_GRP)) u_alloc (
      .clk     (clk),
      .rst_n   (rst_n),
      .grp_en  (grp_live),
      .free    (free),
      .pin_hit (pin_hit),
      .pin_sel (pin_sel),
      .sig_hit (sig_hit),
      .sig_pin (sig_pin)
   );

   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      pxb_pad u_pad (
         .clk      (clk),
         .rst_n    (rst_n),
         .active   (xbar_en && pin_digital[p]),
         .digital  (pin_digital[p]),
         .pushpull (pin_pushpull[p]),
         .hit      (pin_hit[p]),
         .sval     (periph_out[pin_sel[p]]),
         .soe      (periph_oe[pin_sel[p]]),
         .latch    (port_latch[p]),
         .pu_off   (pullup_off),
         .oe       (pad_oe[p]),
         .dout     (pad_out[p]),
         .pu       (pad_pullup[p])
      );
   end

   pxb_in_route #(.NPIN(NPIN), .NSIG(NUM_SIG)) u_in (
      .sig_hit   (sig_hit),
      .sig_pin   (sig_pin),
      .pad_in    (pad_in),
      .periph_in (periph_in)
   );

   assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !xbar_en |-> ((pad_oe == '0) && (&periph_in)));

   assert_analog_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((~pin_digital) & (pad_oe | pad_pullup | gpio_in)) == '0);

endmodule

// File: tb/tb_pin_crossbar.sv
module tb_pin_crossbar;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xbar_en;
   logic [8:0]  grp_en;
   logic [31:0] pin_skip, pin_digital, pin_pushpull, port_latch, pad_in;
   logic        pullup_off;
   logic [22:0] periph_out, periph_oe;
   logic [31:0] pad_oe, pad_out, pad_pullup, gpio_in;
   logic [22:0] periph_in;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   pin_crossbar dut (
      .clk(clk), .rst_n(rst_n), .xbar_en(xbar_en), .grp_en(grp_en),
      .pin_skip(pin_skip), .pin_digital(pin_digital), .pin_pushpull(pin_pushpull),
      .pullup_off(pullup_off), .periph_out(periph_out), .periph_oe(periph_oe),
      .port_latch(port_latch), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
      .pad_pullup(pad_pullup), .gpio_in(gpio_in), .periph_in(periph_in)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic base_cfg();
      @(negedge clk);
      xbar_en = 1'b1; grp_en = '0; pin_skip = '0; pin_digital = '1;
      pin_pushpull = '1; pullup_off = 1'b0; periph_out = '0; periph_oe = '1;
      port_latch = '0; pad_in = '0;
   endtask

   task automatic t_off();
      base_cfg();
      xbar_en = 1'b0; grp_en = '1; port_latch = '1; periph_out = '1;
      #1;
      chk("R1 oe", pad_oe, 32'h0);
      chk("R1 periph_in", 32'(periph_in), 32'h007F_FFFF);
      chk("R9 pullup idle", pad_pullup, 32'hFFFF_FFFF);
   endtask

   task automatic t_gpio();
      base_cfg();
      port_latch = 32'hA5A5_5A5A;
      #1;
      chk("R6 oe", pad_oe, 32'hFFFF_FFFF);
      chk("R6 out", pad_out, 32'hA5A5_5A5A);
      chk("R9 pullup vs low drive", pad_pullup, 32'hA5A5_5A5A);
   endtask

   task automatic t_priority();
      base_cfg();
      grp_en = 9'b000000011; periph_out = 23'h00002A;
      #1;
      chk("R2 R3 two groups", pad_out, 32'h0000_002A);
      @(negedge clk);
      grp_en = 9'b000000010;
      #1;
      chk("R3 disabled group takes none", pad_out, 32'h0000_000A);
   endtask

   task automatic t_skip();
      base_cfg();
      grp_en = 9'b1; periph_out = 23'h3; pin_skip = 32'h5;
      #1;
      chk("R4 skip", pad_out, 32'h0000_000A);
      chk("R4 skip gpio driven", pad_oe, 32'hFFFF_FFFF);
   endtask

   task automatic t_analog();
      base_cfg();
      grp_en = 9'b1; periph_out = 23'h2; pin_digital = ~32'h2; pad_in = '1;
      #1;
      chk("R5 oe", pad_oe, ~32'h2);
      chk("R5 out", pad_out, 32'h4);
      chk("R5 pullup", pad_pullup & 32'h2, 32'h0);
      chk("R5 gpio_in", gpio_in, ~32'h2);
   endtask

   task automatic t_open_drain();
      base_cfg();
      pin_pushpull = '0; port_latch = 32'h0000_FFFF;
      #1;
      chk("R7 oe", pad_oe, 32'hFFFF_0000);
      chk("R7 out", pad_out, 32'h0);
      chk("R9 pullup", pad_pullup, 32'h0000_FFFF);
      @(negedge clk);
      pullup_off = 1'b1;
      #1;
      chk("R9 global off", pad_pullup, 32'h0);
   endtask

   task automatic t_periph_oe();
      base_cfg();
      grp_en = 9'b1; periph_oe = ~23'h1;
      #1;
      chk("R8 oe", pad_oe, ~32'h1);
   endtask

   task automatic t_inputs();
      base_cfg();
      grp_en = 9'b000000011; pad_in = 32'h15;
      #1;
      chk("R11 R10 routed inputs", 32'(periph_in), 32'h007F_FFD5);
   endtask

   task automatic t_exhaust();
      base_cfg();
      grp_en = '1; pin_skip = 32'h0000_FFFF; periph_out = '1;
      #1;
      chk("R10 periph_in", 32'(periph_in), 32'h007F_0000);
      chk("R10 out", pad_out, 32'hFFFF_0000);
   endtask

   task automatic t_same_cycle();
      base_cfg();
      grp_en = 9'b1; periph_out = 23'h3;
      @(posedge clk);
      #5;
      pin_skip = 32'h1; periph_out = 23'h2;
      #1;
      chk("R12 remap and value", pad_out, 32'h0000_0004);
      chk("R12 before edge", 32'(clk), 32'h1);
   endtask

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      xbar_en = 1'b0; grp_en = '0; pin_skip = '0; pin_digital = '1;
      pin_pushpull = '1; pullup_off = 1'b0; periph_out = '0; periph_oe = '1;
      port_latch = '0; pad_in = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset state oe", pad_oe, 32'h0);
      rst_n = 1'b1;
      t_off();
      t_gpio();
      t_priority();
      t_skip();
      t_analog();
      t_open_drain();
      t_periph_oe();
      t_inputs();
      t_exhaust();
      t_same_cycle();
      repeat (2) @(posedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule